// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller covering four banks of 32 pins. Only pins below the `PIN_COUNT` parameter exist. Each pin can be an input or an output. Outputs are driven from a latch that software changes through separate set and clear words. Inputs are brought in through two sampling flops. Edges on those sampled inputs can be latched into a sticky status word, and software clears that word one bit at a time.

Software reaches the block over a single-cycle 32-bit bus. A write takes effect on the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr` while `bus_rd` is high.

The status words feed three interrupt lines. Two lines are dedicated to pins 0 and 1, and the third is shared by every other pin. A wake request is raised when a selected input pin changes level while the core reports itself halted. Each bank also stores two alternate-function words, but the block does not use them to steer any pin.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, every register reads zero, `pin_oe` and `pin_out` are zero, and all three interrupt lines and `wake_req` are low.
- R2: A write to a set word ORs the data into the output latch. A write to a clear word clears the latch bits where the data has ones. The set words are at 0x018/0x01C/0x020/0x118 and the clear words are at 0x024/0x028/0x02C/0x124, for banks 0 to 3. Both kinds read as zero. `pin_out` equals the latch and `pin_oe` equals the direction word.
- R3: The direction word (0x00C/0x010/0x014/0x10C, bit = 1 means output) is read/write. The level word (0x000/0x004/0x008/0x100) returns the latch on output bits and the sampled input on input bits. A pin change is visible in the level word from the second clock edge onward.
- R4: An input pin whose sampled level goes from 0 to 1 sets its status bit when its rising-enable bit is set (0x030/0x034/0x038/0x130). A change from 1 to 0 sets the status bit when its falling-enable bit is set (0x03C/0x040/0x044/0x13C). The bit is set on the third clock edge after the pin changes. Pins configured as outputs never set status.
- R5: A write to a status word (0x048/0x04C/0x050/0x148) clears the bits written as one. If an edge arrives on the same clock edge as the clear, the bit stays set.
- R6: `irq_pin0` follows status bit 0 of bank 0. `irq_pin1` follows status bit 1 of bank 0. `irq_rest` is the OR of every other status bit in all banks.
- R7: `wake_req` is high for one cycle when an input pin changes sampled level, that pin's bit is set in its bank's wake mask, and `cpu_halted` is high. The wake masks are 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F for banks 0 to 3.
- R8: Pin indices at or above `PIN_COUNT` have no effect. Their bits in the direction, latch, enable, status and level words stay zero, and they are never driven.
- R9: Offsets at 0x200 and above read as zero and writes to them change nothing. The alternate-function words are plain read/write storage: the low words are at 0x054/0x05C/0x064/0x06C and the high words are at 0x058/0x060/0x068/0x070.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when bus_rd is low |
| pin_in | input | 128 | Pin levels from the pads |
| pin_out | output | 128 | Output latch |
| pin_oe | output | 128 | Output enable per pin |
| cpu_halted | input | 1 | Core halted, enables wake detection |
| irq_pin0 | output | 1 | Interrupt for pin 0 |
| irq_pin1 | output | 1 | Interrupt for pin 1 |
| irq_rest | output | 1 | Shared interrupt for all other pins |
| wake_req | output | 1 | One-cycle wake request |

## Verification
A wrong sampling or previous-level flop shows up as a missing, extra or misplaced status bit. It is read back, or seen on an interrupt line, three edges after the pin moves. An interrupt line is a pure function of the status flops, so a wrong status bit reaches the port in the same cycle it is latched. A wrong latch or direction bit shows on `pin_out` or `pin_oe` immediately after the write edge. It also changes which pins can raise edges or wake requests on later input changes, so the bench re-reads every register at intervals during long random runs.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

    localparam int BANKS  = 4;
    localparam int BANK_W = 32;
    localparam int ADDR_W = 12;
    localparam int BSEL_W = $clog2(BANKS);

    typedef enum logic [3:0] {
        RK_NONE, RK_LEVEL, RK_SET, RK_CLR, RK_DIR,
        RK_RISE, RK_FALL, RK_EDGE, RK_ALT_LO, RK_ALT_HI
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e          kind;
        logic [BSEL_W-1:0]  bank;
    } reg_sel_t;

    // Offset map: banks 0..2 of the pin words are packed in groups of three
    // below 0x054; bank 3 repeats the same low byte with offset bit 8 set.
    function automatic reg_sel_t decode_offset(input logic [ADDR_W-1:0] a);
        reg_sel_t s;
        int       w;
        s.kind = RK_NONE;
        s.bank = '0;
        w = int'(a[7:2]);
        if (a < ADDR_W'(12'h200) && a[1:0] == 2'b00) begin
            if (a[8]) begin
                s.bank = BSEL_W'(3);
                case (a[7:0])
                    8'h00:   s.kind = RK_LEVEL;
                    8'h0C:   s.kind = RK_DIR;
                    8'h18:   s.kind = RK_SET;
                    8'h24:   s.kind = RK_CLR;
                    8'h30:   s.kind = RK_RISE;
                    8'h3C:   s.kind = RK_FALL;
                    8'h48:   s.kind = RK_EDGE;
                    default: s.kind = RK_NONE;
                endcase
            end else if (w <= 20) begin
                s.bank = BSEL_W'(w % 3);
                case (w / 3)
                    0:       s.kind = RK_LEVEL;
                    1:       s.kind = RK_DIR;
                    2:       s.kind = RK_SET;
                    3:       s.kind = RK_CLR;
                    4:       s.kind = RK_RISE;
                    5:       s.kind = RK_FALL;
                    default: s.kind = RK_EDGE;
                endcase
            end else if (w <= 28) begin
                s.bank = BSEL_W'((w - 21) / 2);
                s.kind = ((w - 21) % 2 == 0) ? RK_ALT_LO : RK_ALT_HI;
            end
        end
        return s;
    endfunction

    function automatic logic [BANK_W-1:0] wake_mask(input int b);
        case (b)
            0:       return 32'h8003_FE1B;
            1:       return 32'h0020_01FC;
            2:       return 32'hEC08_0000;
            default: return 32'h0012_007F;
        endcase
    endfunction

    function automatic logic [BANK_W-1:0] bank_valid(input int b, input int pins);
        logic [BANK_W-1:0] m;
        for (int i = 0; i < BANK_W; i++) m[i] = ((b * BANK_W + i) < pins);
        return m;
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] level,
    output logic [W-1:0] prev
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            level  <= '0;
            prev   <= '0;
        end else begin
            stage1 <= d_in;
            level  <= stage1;
            prev   <= level;
        end
    end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_ctrl_pkg::*;
#(
    parameter logic [BANK_W-1:0] VALID = '1,
    parameter logic [BANK_W-1:0] WAKE  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] pin_in,
    input  logic              wr_en,
    input  reg_kind_e         wr_kind,
    input  logic [BANK_W-1:0] wdata,
    input  reg_kind_e         rd_kind,
    input  logic              cpu_halted,
    output logic [BANK_W-1:0] dir_q,
    output logic [BANK_W-1:0] latch_q,
    output logic [BANK_W-1:0] status_q,
    output logic [BANK_W-1:0] rd_data,
    output logic              wake_hit
);

    logic [BANK_W-1:0] lvl, prev_lvl;
    logic [BANK_W-1:0] rise_en, fall_en, alt_lo, alt_hi;
    logic [BANK_W-1:0] new_edge, w1c;

    gpio_pin_sync #(.W(BANK_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pin_in & VALID),
        .level (lvl),
        .prev  (prev_lvl)
    );

    assign new_edge = ((lvl & ~prev_lvl & rise_en) |
                       (~lvl & prev_lvl & fall_en)) & ~dir_q;
    assign w1c      = (wr_en && wr_kind == RK_EDGE) ? wdata : '0;
    assign wake_hit = cpu_halted && |((lvl ^ prev_lvl) & ~dir_q & WAKE & VALID);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q    <= '0;
            latch_q  <= '0;
            status_q <= '0;
            rise_en  <= '0;
            fall_en  <= '0;
            alt_lo   <= '0;
            alt_hi   <= '0;
        end else begin
            status_q <= (status_q & ~w1c) | new_edge;
            if (wr_en) begin
                case (wr_kind)
                    RK_SET:    latch_q <= latch_q | (wdata & VALID);
                    RK_CLR:    latch_q <= latch_q & ~wdata;
                    RK_DIR:    dir_q   <= wdata & VALID;
                    RK_RISE:   rise_en <= wdata & VALID;
                    RK_FALL:   fall_en <= wdata & VALID;
                    RK_ALT_LO: alt_lo  <= wdata;
                    RK_ALT_HI: alt_hi  <= wdata;
                    default:   ;
                endcase
            end
        end
    end

    always_comb begin
        case (rd_kind)
            RK_LEVEL:  rd_data = ((latch_q & dir_q) | (lvl & ~dir_q)) & VALID;
            RK_DIR:    rd_data = dir_q;
            RK_RISE:   rd_data = rise_en;
            RK_FALL:   rd_data = fall_en;
            RK_EDGE:   rd_data = status_q;
            RK_ALT_LO: rd_data = alt_lo;
            RK_ALT_HI: rd_data = alt_hi;
            default:   rd_data = '0;
        endcase
    end

    AST_SET_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && wr_kind == RK_SET) |->
            ((latch_q & $past(wdata & VALID)) == $past(wdata & VALID))); // R2

    AST_NO_EDGE_ON_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q & ~$past(status_q) & $past(dir_q)) == '0); // R4

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && wr_kind == RK_EDGE) |->
            ((status_q & $past(wdata) & ~$past(new_edge)) == '0)); // R5

endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge
    import gpio_ctrl_pkg::*;
#(
    parameter int NB = 4
) (
    input  logic [NB-1:0][BANK_W-1:0] status,
    output logic                      irq_pin0,
    output logic                      irq_pin1,
    output logic                      irq_rest
);

    always_comb begin
        irq_pin0 = status[0][0];
        irq_pin1 = status[0][1];
        irq_rest = |status[0][BANK_W-1:2];
        for (int b = 1; b < NB; b++) irq_rest = irq_rest | (|status[b]);
    end

endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
    import gpio_ctrl_pkg::*;
#(
    parameter int PIN_COUNT = 120
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [BANK_W-1:0]         bus_wdata,
    output logic [BANK_W-1:0]         bus_rdata,
    input  logic [BANKS*BANK_W-1:0]   pin_in,
    output logic [BANKS*BANK_W-1:0]   pin_out,
    output logic [BANKS*BANK_W-1:0]   pin_oe,
    input  logic                      cpu_halted,
    output logic                      irq_pin0,
    output logic                      irq_pin1,
    output logic                      irq_rest,
    output logic                      wake_req
);

    localparam int TOTAL = BANKS * BANK_W;

    reg_sel_t                       sel;
    logic [BANKS-1:0][BANK_W-1:0]   status_all;
    logic [BANKS-1:0][BANK_W-1:0]   rd_all;
    logic [BANKS-1:0]               wake_all;
    logic [TOTAL-1:0]               valid_all;

    assign sel = decode_offset(bus_addr);

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        localparam logic [BANK_W-1:0] VM = bank_valid(b, PIN_COUNT);
        logic bank_wr;

        assign bank_wr = bus_wr && (int'(sel.bank) == b) && (sel.kind != RK_NONE);
        assign valid_all[b*BANK_W +: BANK_W] = VM;

        gpio_bank #(.VALID(VM), .WAKE(wake_mask(b))) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_in     (pin_in[b*BANK_W +: BANK_W]),
            .wr_en      (bank_wr),
            .wr_kind    (sel.kind),
            .wdata      (bus_wdata),
            .rd_kind    (sel.kind),
            .cpu_halted (cpu_halted),
            .dir_q      (pin_oe[b*BANK_W +: BANK_W]),
            .latch_q    (pin_out[b*BANK_W +: BANK_W]),
            .status_q   (status_all[b]),
            .rd_data    (rd_all[b]),
            .wake_hit   (wake_all[b])
        );
    end

    gpio_irq_merge #(.NB(BANKS)) u_irq (
        .status   (status_all),
        .irq_pin0 (irq_pin0),
        .irq_pin1 (irq_pin1),
        .irq_rest (irq_rest)
    );

    assign bus_rdata = bus_rd ? rd_all[sel.bank] : '0;
    assign wake_req  = |wake_all;

    AST_NO_DRIVE_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe | pin_out) & ~valid_all) == '0); // R8

    AST_WAKE_NEEDS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> cpu_halted); // R7

    AST_HIGH_OFFSET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr >= ADDR_W'(12'h200)) |-> (bus_rdata == '0)); // R9

endmodule

// File: tb/sim_gpio_ctrl.sv
module sim_gpio_ctrl;
    import gpio_ctrl_pkg::*;

    localparam int PINS = 120;
    localparam int K_LEVEL = 0, K_SET = 1, K_CLR = 2, K_DIR = 3, K_RISE = 4,
                   K_FALL = 5, K_EDGE = 6, K_ALO = 7, K_AHI = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [127:0] pin_in = '0;
    logic [127:0] pin_out, pin_oe;
    logic         cpu_halted = 1'b0;
    logic         irq_pin0, irq_pin1, irq_rest, wake_req;

    gpio_ctrl #(.PIN_COUNT(PINS)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .cpu_halted(cpu_halted), .irq_pin0(irq_pin0), .irq_pin1(irq_pin1),
        .irq_rest(irq_rest), .wake_req(wake_req)
    );

    always #10 clk = ~clk;

    int  n_chk = 0, n_fail = 0;
    bit  done = 0;
    bit [31:0] m_dir[4], m_lat[4], m_rise[4], m_fall[4], m_st[4], m_lv[4], m_alo[4], m_ahi[4];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic bit [31:0] vm(input int b);
        bit [31:0] m;
        for (int i = 0; i < 32; i++) m[i] = ((b * 32 + i) < PINS);
        return m;
    endfunction

    function automatic bit [31:0] wk(input int b);
        case (b)
            0: return 32'h8003FE1B;
            1: return 32'h002001FC;
            2: return 32'hEC080000;
            default: return 32'h0012007F;
        endcase
    endfunction

    function automatic logic [11:0] addr_of(input int k, input int b);
        logic [11:0] base;
        case (k)
            K_LEVEL: base = 12'h000;
            K_DIR:   base = 12'h00C;
            K_SET:   base = 12'h018;
            K_CLR:   base = 12'h024;
            K_RISE:  base = 12'h030;
            K_FALL:  base = 12'h03C;
            K_EDGE:  base = 12'h048;
            K_ALO:   return 12'h054 + 12'(8 * b);
            default: return 12'h058 + 12'(8 * b);
        endcase
        return (b == 3) ? base + 12'h100 : base + 12'(4 * b);
    endfunction

    function automatic bit [31:0] exp_read(input int k, input int b);
        case (k)
            K_LEVEL: return ((m_lat[b] & m_dir[b]) | (m_lv[b] & ~m_dir[b])) & vm(b);
            K_DIR:   return m_dir[b];
            K_RISE:  return m_rise[b];
            K_FALL:  return m_fall[b];
            K_EDGE:  return m_st[b];
            K_ALO:   return m_alo[b];
            K_AHI:   return m_ahi[b];
            default: return 32'h0;
        endcase
    endfunction

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic do_write(input int k, input int b, input bit [31:0] d);
        bus_write(addr_of(k, b), d);
        case (k)
            K_SET:  m_lat[b] |= d & vm(b);
            K_CLR:  m_lat[b] &= ~d;
            K_DIR:  m_dir[b] = d & vm(b);
            K_RISE: m_rise[b] = d & vm(b);
            K_FALL: m_fall[b] = d & vm(b);
            K_EDGE: m_st[b] &= ~d;
            K_ALO:  m_alo[b] = d;
            K_AHI:  m_ahi[b] = d;
            default: ;
        endcase
    endtask

    task automatic do_pins(input logic [127:0] nv);
        bit exp_wake = 0, seen = 0;
        @(negedge clk);
        for (int b = 0; b < 4; b++) begin
            bit [31:0] nb, ob;
            nb = nv[b*32 +: 32] & vm(b);
            ob = m_lv[b];
            m_st[b] |= ((~ob & nb & m_rise[b]) | (ob & ~nb & m_fall[b])) & ~m_dir[b];
            if (cpu_halted && ((ob ^ nb) & ~m_dir[b] & wk(b)) != 0) exp_wake = 1;
            m_lv[b] = nb;
        end
        pin_in = nv;
        repeat (4) begin
            @(negedge clk);
            if (wake_req) seen = 1;
        end
        check("R7 wake request", 32'(seen), 32'(exp_wake));
    endtask

    task automatic check_outputs(input string req);
        for (int b = 0; b < 4; b++) begin
            check({req, " R2 pin_out"}, pin_out[b*32 +: 32], m_lat[b]);
            check({req, " R2 pin_oe"}, pin_oe[b*32 +: 32], m_dir[b]);
        end
        check({req, " R6 irq_pin0"}, 32'(irq_pin0), 32'(m_st[0][0]));
        check({req, " R6 irq_pin1"}, 32'(irq_pin1), 32'(m_st[0][1]));
        check({req, " R6 irq_rest"}, 32'(irq_rest),
              32'((m_st[0][31:2] != 0) || m_st[1] != 0 || m_st[2] != 0 || m_st[3] != 0));
    endtask

    task automatic full_compare(input string req);
        logic [31:0] d;
        for (int b = 0; b < 4; b++)
            for (int k = 0; k < 9; k++) begin
                bus_read(addr_of(k, b), d);
                check($sformatf("%s reg k%0d b%0d", req, k, b), d, exp_read(k, b));
            end
        check_outputs(req);
    endtask

    initial begin
        logic [31:0] d;
        void'($urandom(32'd7331));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 wake low", 32'(wake_req), 32'h0);
        full_compare("R1 reset");

        // R8 / R2 / R3: bank 3 partly beyond PIN_COUNT
        do_write(K_DIR, 3, 32'hFFFFFFFF);
        bus_read(addr_of(K_DIR, 3), d);
        check("R8 dir above pin count", d, 32'h00FFFFFF);
        do_write(K_SET, 3, 32'hFFFFFFFF);
        check("R8 pin_out above pin count", pin_out[127:96], 32'h00FFFFFF);
        do_write(K_CLR, 3, 32'h0000FFFF);
        check("R2 clear word", pin_out[127:96], 32'h00FF0000);
        bus_read(addr_of(K_SET, 3), d);
        check("R2 set word reads zero", d, 32'h0);
        bus_read(addr_of(K_CLR, 0), d);
        check("R2 clear word reads zero", d, 32'h0);
        bus_read(addr_of(K_LEVEL, 3), d);
        check("R3 level of outputs", d, 32'h00FF0000);

        // R9: high offsets and alternate-function storage
        do_write(K_ALO, 0, 32'h12345678);
        bus_write(12'h254, 32'hDEADBEEF);
        bus_read(12'h254, d);
        check("R9 high offset reads zero", d, 32'h0);
        bus_read(addr_of(K_ALO, 0), d);
        check("R9 high write ignored", d, 32'h12345678);
        do_write(K_AHI, 2, 32'hA5A5F00F);
        full_compare("R9 alt storage");

        // R4 / R6: edges on pin 0, pin 40, pin 1
        do_write(K_RISE, 0, 32'h00000063);
        do_write(K_FALL, 0, 32'h00000003);
        do_write(K_RISE, 1, 32'h00000100);
        do_pins(128'h1);
        bus_read(addr_of(K_EDGE, 0), d);
        check("R4 rising edge pin0", d, 32'h1);
        check_outputs("R6 pin0 only");
        do_pins(128'h1 | (128'h1 << 40));
        check("R6 irq_rest from pin40", 32'(irq_rest), 32'h1);
        do_write(K_EDGE, 0, 32'h1);
        check("R5 w1c clears pin0", 32'(irq_pin0), 32'h0);
        do_write(K_EDGE, 1, 32'hFFFFFFFF);
        do_pins(128'h3 | (128'h1 << 40));
        do_write(K_EDGE, 0, 32'h2);
        do_pins(128'h1 | (128'h1 << 40));
        bus_read(addr_of(K_EDGE, 0), d);
        check("R4 falling edge pin1", d, 32'h2);
        check_outputs("R6 pin1");
        do_write(K_EDGE, 0, 32'hFFFFFFFF);

        // R4: an output pin never sets status
        do_write(K_DIR, 0, 32'h00000040);
        do_pins(pin_in | (128'h1 << 6));
        bus_read(addr_of(K_EDGE, 0), d);
        check("R4 output pin no edge", d, 32'h0);

        // R8: pin above PIN_COUNT is ignored
        do_pins(pin_in | (128'h1 << 120));
        bus_read(addr_of(K_EDGE, 3), d);
        check("R8 status above pin count", d, 32'h0);
        bus_read(addr_of(K_LEVEL, 3), d);
        check("R8 level above pin count", d, exp_read(K_LEVEL, 3));

        // R5: edge and clear on the same clock edge
        @(negedge clk);
        pin_in[5] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_addr = addr_of(K_EDGE, 0); bus_wdata = 32'h20; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        m_lv[0][5] = 1'b1;
        m_st[0][5] = 1'b1;
        repeat (2) @(negedge clk);
        bus_read(addr_of(K_EDGE, 0), d);
        check("R5 edge wins over clear", d, 32'h20);
        do_write(K_EDGE, 0, 32'h20);

        // R7: wake only while halted and only for masked pins
        cpu_halted = 1'b1;
        do_pins(pin_in ^ 128'h1);
        do_pins(pin_in ^ 128'h4);
        cpu_halted = 1'b0;
        do_pins(pin_in ^ 128'h1);
        full_compare("R3 R4 directed");

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int op = int'($urandom_range(0, 9));
            int b = int'($urandom_range(0, 3));
            if (op < 6) begin
                int k = int'($urandom_range(1, 8));
                do_write(k, b, $urandom & $urandom);
            end else begin
                logic [127:0] flip = {$urandom & $urandom, $urandom & $urandom,
                                      $urandom & $urandom, $urandom & $urandom};
                cpu_halted = $urandom_range(0, 1) == 1;
                do_pins(pin_in ^ flip);
            end
            if (it % 40 == 39) full_compare("R2 R3 R4 R5 R6 random");
        end
        full_compare("R1-final random");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule